// File: doc/BRIEF.md
# Instruction Fetch Wait-State Controller

This block sits on the memory side of a pipelined processor's instruction fetch port. In every cycle the processor presents a request pair: an active-low memory request and a sequential flag. It also presents a halfword-granular address and a halfword-mode flag. These inputs describe the access in the following cycle. The controller sorts each request into a non-sequential fetch, a sequential fetch, an internal cycle or a reserved code.

Non-sequential fetches get one wait state and sequential fetches get none. The controller reads a computed instruction memory model and returns either a full word or a zero-extended halfword. An abort flag travels in the same cycle as the data it belongs to. While a wait state is pending, the captured access is held and new request inputs are ignored.

A reserved request code produces an idle cycle and sets a sticky error flag. The first fetch after reset always takes the non-sequential path.

Top module: `ifetch_wait_ctrl`

## Requirements
- R1: The request pair {req_n, seq} decodes as follows: 00 is a non-sequential fetch, 01 is a sequential fetch, 10 is an internal cycle and 11 is reserved. An internal or reserved cycle produces neither wait_o nor rvalid in the following cycle.
- R2: A sequential fetch presented in cycle t is captured at the end of t. In cycle t+1, rvalid is high, wait_o is low and rdata carries the data.
- R3: A non-sequential fetch presented in cycle t raises wait_o with rvalid low in cycle t+1. It delivers rvalid and rdata in cycle t+2, with wait_o low again.
- R4: While wait_o is high, the request, address and mode inputs are ignored. The pending access completes with its captured address and mode, and a reserved code presented then does not set err_o.
- R5: The first fetch after reset takes the non-sequential timing of R3 even if it is marked sequential.
- R6: Memory word w holds {w[15:0] ^ 16'hA5A5, w[15:0]*3 + 7} (16-bit arithmetic). The word index is address bits [MEM_AW+1:2], and the index wraps. In word mode (half_mode low), rdata is the whole word and address bit 1 has no effect.
- R7: In halfword mode, address bit 1 set returns bits [31:16] of the word and clear returns bits [15:0]. In both cases the halfword is zero-extended to 32 bits.
- R8: With ABORT_EN set, a fetch whose byte address {addr, 1'b0} lies in [ABORT_LO, ABORT_HI] inclusive raises abort_o in its rvalid cycle, and rdata is zero in that cycle.
- R9: With ABORT_EN clear, abort_o stays low at all times.
- R10: A reserved request accepted when no wait is pending sets err_o in the next cycle. err_o then stays set until reset.
- R11: A synchronous active-high reset clears wait_o, rvalid, abort_o and err_o, and cancels any pending access. rdata is zero whenever rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Memory request, active low |
| seq | input | 1 | Sequential access flag |
| addr | input | 31 | Fetch address bits 31 down to 1 |
| half_mode | input | 1 | High selects halfword fetches, low selects word fetches |
| wait_o | output | 1 | Wait state in progress |
| rvalid | output | 1 | rdata and abort_o are valid this cycle |
| rdata | output | 32 | Fetched instruction data |
| abort_o | output | 1 | Fetch abort, aligned with rdata |
| err_o | output | 1 | Sticky flag for a reserved request code |

## Verification
The bench builds the main instance with MEM_AW=4 and an abort window from 0x40 to 0x47. It also builds a second instance with ABORT_EN=0 that receives the same stimulus. The 16-word memory makes a sweep over byte addresses 0 to 0x5E wrap through the whole memory. That sweep, run in both modes and for both fetch kinds, crosses both edges of the abort window. The second instance shows that abort stays low on the same accesses. Pipelined sequential bursts, requests changed during a wait state, reserved and internal codes, and a reset in the middle of a run cover the timing and the sticky flag.

// File: rtl/ifetch_wait_ctrl.sv
module ifetch_wait_ctrl #(
  parameter int          MEM_AW   = 6,
  parameter bit          ABORT_EN = 1'b1,
  parameter logic [31:0] ABORT_LO = 32'h0000_1000,
  parameter logic [31:0] ABORT_HI = 32'h0000_10FF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_n,
  input  logic        seq,
  input  logic [31:1] addr,
  input  logic        half_mode,
  output logic        wait_o,
  output logic        rvalid,
  output logic [31:0] rdata,
  output logic        abort_o,
  output logic        err_o
);
  localparam int IDX_HI = MEM_AW + 1;

  typedef enum logic [1:0] {CYC_N = 2'b00, CYC_S = 2'b01, CYC_I = 2'b10, CYC_R = 2'b11} cyc_e;

  cyc_e        cyc_in;
  logic        busy, waiting, first_pend, err_q, cur_half;
  logic [31:1] cur_addr;
  logic [31:0] word, sel;
  logic        in_win;

  assign cyc_in = cyc_e'({req_n, seq});

  function automatic logic [31:0] mem_word(input logic [MEM_AW-1:0] w);
    logic [15:0] x;
    x = 16'(w);
    return {x ^ 16'hA5A5, x * 16'd3 + 16'd7};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      waiting    <= 1'b0;
      first_pend <= 1'b1;
      err_q      <= 1'b0;
      cur_half   <= 1'b0;
      cur_addr   <= '0;
    end else if (waiting) begin
      waiting <= 1'b0;
    end else begin
      case (cyc_in)
        CYC_N, CYC_S: begin
          busy       <= 1'b1;
          waiting    <= (cyc_in == CYC_N) || first_pend;
          first_pend <= 1'b0;
          cur_addr   <= addr;
          cur_half   <= half_mode;
        end
        CYC_R: begin
          busy    <= 1'b0;
          waiting <= 1'b0;
          err_q   <= 1'b1;
        end
        default: begin
          busy    <= 1'b0;
          waiting <= 1'b0;
        end
      endcase
    end
  end

  assign word   = mem_word(cur_addr[IDX_HI:2]);
  assign sel    = !cur_half     ? word :
                  cur_addr[1]   ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
  assign in_win = ABORT_EN && ({cur_addr, 1'b0} >= ABORT_LO) && ({cur_addr, 1'b0} <= ABORT_HI);

  assign wait_o  = waiting;
  assign rvalid  = busy && !waiting;
  assign abort_o = rvalid && in_win;
  assign rdata   = (rvalid && !in_win) ? sel : 32'h0;
  assign err_o   = err_q;

  assert_wait_single_R3: assert property (@(posedge clk) disable iff (rst) wait_o |=> !wait_o);
  assert_wait_then_data_R3: assert property (@(posedge clk) disable iff (rst) wait_o |=> rvalid);
  assert_hold_during_wait_R4: assert property (@(posedge clk) disable iff (rst)
    wait_o |=> ($stable(cur_addr) && $stable(cur_half)));
  assert_idle_no_access_R1: assert property (@(posedge clk) disable iff (rst)
    (!wait_o && req_n) |=> (!wait_o && !rvalid));
  assert_abort_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (rvalid && rdata == 32'h0));
  assert_abort_disabled_R9: assert property (@(posedge clk) disable iff (rst) ABORT_EN || !abort_o);
  assert_err_set_R10: assert property (@(posedge clk) disable iff (rst)
    (!wait_o && req_n && seq) |=> err_o);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst) err_o |=> err_o);
  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == 32'h0 && !abort_o));
endmodule

// File: tb/ifetch_wait_ctrl_tb.sv
module ifetch_wait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_n = 1'b1, seq = 1'b0, half_mode = 1'b0;
  logic [31:1] addr = '0;
  logic        fwait, rvalid, abort_o, err_o;
  logic [31:0] rdata;
  logic        nw, nv, nab, nerr;
  logic [31:0] nd;

  int  tests = 0, fails = 0;
  bit  first_f = 1'b1;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  ifetch_wait_ctrl #(.MEM_AW(4), .ABORT_EN(1'b1), .ABORT_LO(32'h40), .ABORT_HI(32'h47)) u_dut (
    .clk(clk), .rst(rst), .req_n(req_n), .seq(seq), .addr(addr), .half_mode(half_mode),
    .wait_o(fwait), .rvalid(rvalid), .rdata(rdata), .abort_o(abort_o), .err_o(err_o));

  ifetch_wait_ctrl #(.MEM_AW(4), .ABORT_EN(1'b0), .ABORT_LO(32'h40), .ABORT_HI(32'h47)) u_dut_noab (
    .clk(clk), .rst(rst), .req_n(req_n), .seq(seq), .addr(addr), .half_mode(half_mode),
    .wait_o(nw), .rvalid(nv), .rdata(nd), .abort_o(nab), .err_o(nerr));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] b);
    logic [15:0] w;
    w = {12'h0, b[5:2]};
    return {w ^ 16'hA5A5, w * 16'd3 + 16'd7};
  endfunction

  function automatic bit exp_abort(input logic [31:0] b);
    return (b >= 32'h40) && (b <= 32'h47);
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] b, input bit h);
    logic [31:0] wd;
    wd = exp_word(b);
    if (exp_abort(b)) return 32'h0;
    if (!h) return wd;
    return b[1] ? {16'h0, wd[31:16]} : {16'h0, wd[15:0]};
  endfunction

  task automatic check_data(input logic [31:0] b, input bit h);
    check("R2 R3 rvalid", {31'h0, rvalid}, 32'h1);
    check("R3 wait low in data cycle", {31'h0, fwait}, 32'h0);
    check(h ? "R7" : "R6", rdata, exp_data(b, h));
    check("R8", {31'h0, abort_o}, {31'h0, exp_abort(b)});
    check("R9", {31'h0, nab}, 32'h0);
  endtask

  task automatic do_fetch(input bit s, input logic [31:0] b, input bit h);
    @(negedge clk);
    req_n = 1'b0; seq = s; addr = b[31:1]; half_mode = h;
    @(negedge clk);
    req_n = 1'b1; seq = 1'b0;
    if (!s || first_f) begin
      check(first_f && s ? "R5" : "R3", {30'h0, fwait, rvalid}, 32'h2);
      @(negedge clk);
    end else begin
      check("R2", {31'h0, fwait}, 32'h0);
    end
    first_f = 1'b0;
    check_data(b, h);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] b;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {27'h0, fwait, rvalid, abort_o, err_o, 1'b0}, 32'h0);
    check("R11 reset data", rdata, 32'h0);
    @(negedge clk); rst = 1'b0;

    // first fetch marked sequential still waits
    do_fetch(1'b1, 32'h8, 1'b0);

    // sweep: both modes, both fetch kinds
    for (int h = 0; h < 2; h++)
      for (int k = 0; k < 2; k++)
        for (int a = 0; a < 32'h60; a += 2) do_fetch(k[0], 32'(a), h[0]);

    // word mode: bit 1 ignored
    do_fetch(1'b0, 32'h16, 1'b0);

    // internal cycle: no access
    @(negedge clk); req_n = 1'b1; seq = 1'b0;
    @(negedge clk);
    check("R1 internal", {29'h0, fwait, rvalid, err_o}, 32'h0);
    check("R11 idle data zero", rdata, 32'h0);

    // inputs ignored during wait, including a reserved code
    @(negedge clk); req_n = 1'b0; seq = 1'b0; addr = 31'h10; half_mode = 1'b1;
    @(negedge clk);
    check("R3 wait", {30'h0, fwait, rvalid}, 32'h2);
    req_n = 1'b1; seq = 1'b1; addr = 31'h2A; half_mode = 1'b0;
    @(negedge clk);
    req_n = 1'b1; seq = 1'b0;
    check("R4 held addr", rdata, exp_data(32'h20, 1'b1));
    check("R4 reserved ignored", {31'h0, err_o}, 32'h0);

    // pipelined burst: N then back-to-back S
    @(negedge clk); req_n = 1'b0; seq = 1'b0; addr = 31'h2; half_mode = 1'b0;
    @(negedge clk); req_n = 1'b1;
    check("R3 burst wait", {31'h0, fwait}, 32'h1);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      b = 32'h4 + 32'(4 * i);
      check_data(b, 1'b0);
      req_n = 1'b0; seq = 1'b1; addr = (b + 32'h4) >> 1;
      @(negedge clk);
    end
    req_n = 1'b1; seq = 1'b0;
    check_data(32'h1C, 1'b0);

    // reserved code sets sticky error
    @(negedge clk); req_n = 1'b1; seq = 1'b1;
    @(negedge clk); req_n = 1'b1; seq = 1'b0;
    check("R10 set", {29'h0, fwait, rvalid, err_o}, 32'h1);
    check("R1 reserved idle data", rdata, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 sticky", {31'h0, err_o}, 32'h1);
    do_fetch(1'b0, 32'h44, 1'b1);
    check("R10 sticky after fetch", {31'h0, err_o}, 32'h1);

    // reset in the middle of a pending wait
    @(negedge clk); req_n = 1'b0; seq = 1'b0; addr = 31'h4;
    @(negedge clk); req_n = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R11 reset mid-access", {28'h0, fwait, rvalid, abort_o, err_o}, 32'h0);
    check("R11 reset data", rdata, 32'h0);
    rst = 1'b0; first_f = 1'b1;
    do_fetch(1'b1, 32'h12, 1'b1);
    do_fetch(1'b1, 32'h14, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule